// File: doc/BRIEF.md
# Scaled Colour-Gradient Pattern Generator

This block paints a test pattern for a raster display. For every active pixel it produces a 12-bit colour word with 4 bits per channel. The active line is cut into equal vertical bands, and the bands run from left to right as red, green, blue and, when enabled, gray. Inside each band an 8-bit pixel counter starts at zero and climbs by one per pixel. The counter is scaled by a per-band fraction (numerator over denominator), and the result sets the brightness of that band's channel, so the band shows a ramp. When the counter wraps inside a wide band, the ramp repeats.

The block is fed the pixel column and the display-enable flag from an external sync generator. It is also fed the active width, the band count and the eight scale bytes from external storage. Its colour output and a matching delayed enable go to the DAC stage. A pattern-enable input blanks the output to black.

The band sequencer is a state machine with five states: IDLE (blanking), RED, GREEN, BLUE and GRAY. The transitions are:
- IDLE→RED: the enable flag is high and the column is zero.
- RED→GREEN and GREEN→BLUE: the last pixel of the current band has been reached.
- BLUE→GRAY: the same border condition, but only when four bands were latched.
- Any state→IDLE: the enable flag is low.
- Line start: a column of zero with the enable flag high restarts at RED from any state.
- Otherwise BLUE (three bands) and GRAY hold until the line ends.

Top module: `grad_pattern_gen`

## Requirements
- R1: While reset is asserted, `rgb_out` is 0 and `de_out` is 0.
- R2: `de_out` equals `disp_en` delayed by one rising clock edge. The colour for the column presented in one cycle appears on `rgb_out` after the next rising edge.
- R3: When `region_count` equals 4 there are four bands; any other value gives three bands. The band width is floor(`active_width` / band count), latched when column 0 is presented with `disp_en` high.
- R4: Bands run left to right in the order red, green, blue, gray. `rgb_out[11:8]` is red, `[7:4]` is green and `[3:0]` is blue. In a single-colour band the other two channels are 0.
- R5: The band counter is 0 at column 0 and at the first pixel of each band. It rises by one per active pixel and wraps from 255 to 0.
- R6: The band's level is the low 4 bits of floor(counter × num / den). The scale bytes are taken from `ramp_num` and `ramp_den` at byte index 0 (red), 1 (green), 2 (blue) and 3 (gray); byte k occupies bits [8k+7:8k].
- R7: A band whose denominator byte is 0 outputs level 0.
- R8: Pixels beyond (band count × band width) stay in the last band, and the counter keeps rising.
- R9: In the gray band, all three channels carry the same level.
- R10: `rgb_out` is 0 when `pattern_en` or `disp_en` was low in the presented cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pattern_en | input | 1 | Turns the pattern on; low gives black |
| disp_en | input | 1 | High during active pixels |
| col | input | 12 | Current pixel column |
| active_width | input | 12 | Active pixels per line |
| region_count | input | 3 | 4 selects four bands, other values three |
| ramp_num | input | 32 | Per-band numerator bytes |
| ramp_den | input | 32 | Per-band denominator bytes |
| rgb_out | output | 12 | Registered colour word |
| de_out | output | 1 | Enable flag delayed to match `rgb_out` |

## Verification
Both `rgb_out` and `de_out` are due exactly one rising edge after the column and enable flag are presented. The band state is resolved in the same cycle as the column, so a band change adds no further delay. The bench drives all inputs at the falling edge, waits for the following rising edge and samples 2 ns later, so every comparison sees the result of the column just driven. One check also samples `de_out` before that edge, to confirm the value has not yet moved.

// File: rtl/gpg_pkg.sv
`timescale 1ns/1ps
package gpg_pkg;
    localparam int NUM_REGIONS = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RED,
        ST_GREEN,
        ST_BLUE,
        ST_GRAY
    } region_e;
endpackage

// File: rtl/gpg_scaler.sv
`timescale 1ns/1ps
// One band lane: scales the shared band counter by num/den, keeping the low bits.
module gpg_scaler #(
    parameter int CNT_W = 8,
    parameter int CH_W  = 4
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] num,
    input  logic [CNT_W-1:0] den,
    output logic [CH_W-1:0]  level
);
    localparam int PROD_W = 2 * CNT_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] den_ext;

    always_comb begin
        prod    = {{CNT_W{1'b0}}, cnt} * {{CNT_W{1'b0}}, num};
        den_ext = {{CNT_W{1'b0}}, den};
        if (den == '0) begin
            level = '0;                       // R7: zero divisor gives black
        end else begin
            level = CH_W'(prod / den_ext);    // R6: truncate to channel width
        end
    end
endmodule

// File: rtl/gpg_region_fsm.sv
`timescale 1ns/1ps
// Band sequencer: tracks the current band and the in-band counter along a line.
module gpg_region_fsm
    import gpg_pkg::*;
#(
    parameter int COL_W = 12,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             disp_en,
    input  logic [COL_W-1:0] col,
    input  logic [COL_W-1:0] active_width,
    input  logic [2:0]       region_count,
    output region_e          cur_region,
    output logic [CNT_W-1:0] cur_cnt
);
    region_e          state_q, state_d, eff_state;
    logic [CNT_W-1:0] cnt_q, cnt_d, eff_cnt;
    logic [COL_W-1:0] pos_q, pos_d, eff_pos;
    logic [COL_W-1:0] width_q, eff_width, width_now;
    logic             four_q, eff_four, four_now;
    logic             line_start, at_border;

    // Effective band for the pixel presented this cycle
    always_comb begin
        four_now   = (region_count == 3'd4);
        width_now  = four_now ? (active_width >> 2) : (active_width / COL_W'(3));
        line_start = disp_en && (col == '0);
        eff_width  = width_q;
        eff_four   = four_q;
        eff_state  = state_q;
        eff_cnt    = cnt_q;
        eff_pos    = pos_q;
        if (!disp_en) begin
            eff_state = ST_IDLE;
            eff_cnt   = '0;
            eff_pos   = '0;
        end else if (line_start) begin
            eff_state = ST_RED;
            eff_cnt   = '0;
            eff_pos   = '0;
            eff_width = width_now;
            eff_four  = four_now;
        end
        at_border = (eff_pos == eff_width - COL_W'(1));
    end

    // Next-state logic
    always_comb begin
        state_d = eff_state;
        unique case (eff_state)
            ST_IDLE:  state_d = ST_IDLE;
            ST_RED:   if (at_border) state_d = ST_GREEN;
            ST_GREEN: if (at_border) state_d = ST_BLUE;
            ST_BLUE:  if (at_border && eff_four) state_d = ST_GRAY;
            ST_GRAY:  state_d = ST_GRAY;
            default:  state_d = ST_IDLE;
        endcase
        if (state_d != eff_state) begin
            cnt_d = '0;
            pos_d = '0;
        end else begin
            cnt_d = eff_cnt + CNT_W'(1);
            pos_d = eff_pos + COL_W'(1);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
            width_q <= '0;
            four_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            pos_q   <= pos_d;
            width_q <= eff_width;
            four_q  <= eff_four;
        end
    end

    // Outputs
    always_comb begin
        cur_region = eff_state;
        cur_cnt    = eff_cnt;
    end

    // R3: the gray band is only reachable when four bands were latched
    a_r3_gray_needs_four: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRAY) |-> four_q);

    // R5: inside one band, consecutive pixels step the counter by one (mod 256)
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && col != '0 && state_q != ST_IDLE && $past(disp_en)
         && $past(col) != '0 && $past(state_q) == state_q)
        |-> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/grad_pattern_gen.sv
`timescale 1ns/1ps
module grad_pattern_gen
    import gpg_pkg::*;
#(
    parameter int COL_W = 12,
    parameter int CNT_W = 8,
    parameter int CH_W  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pattern_en,
    input  logic                         disp_en,
    input  logic [COL_W-1:0]             col,
    input  logic [COL_W-1:0]             active_width,
    input  logic [2:0]                   region_count,
    input  logic [NUM_REGIONS*CNT_W-1:0] ramp_num,
    input  logic [NUM_REGIONS*CNT_W-1:0] ramp_den,
    output logic [3*CH_W-1:0]            rgb_out,
    output logic                         de_out
);
    localparam int RGB_W = 3 * CH_W;

    region_e          cur_region;
    logic [CNT_W-1:0] cur_cnt;
    logic [CH_W-1:0]  lvl [NUM_REGIONS];
    logic [RGB_W-1:0] color;

    gpg_region_fsm #(
        .COL_W(COL_W),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .disp_en     (disp_en),
        .col         (col),
        .active_width(active_width),
        .region_count(region_count),
        .cur_region  (cur_region),
        .cur_cnt     (cur_cnt)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lane
        gpg_scaler #(
            .CNT_W(CNT_W),
            .CH_W (CH_W)
        ) u_scale (
            .cnt  (cur_cnt),
            .num  (ramp_num[g*CNT_W +: CNT_W]),
            .den  (ramp_den[g*CNT_W +: CNT_W]),
            .level(lvl[g])
        );
    end

    always_comb begin
        unique case (cur_region)
            ST_RED:   color = {lvl[0], {(2*CH_W){1'b0}}};
            ST_GREEN: color = {{CH_W{1'b0}}, lvl[1], {CH_W{1'b0}}};
            ST_BLUE:  color = {{(2*CH_W){1'b0}}, lvl[2]};
            ST_GRAY:  color = {lvl[3], lvl[3], lvl[3]};
            default:  color = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgb_out <= '0;
            de_out  <= 1'b0;
        end else begin
            rgb_out <= (pattern_en && disp_en) ? color : '0;
            de_out  <= disp_en;
        end
    end

    // R10: blanking or disabled pattern gives black one edge later
    a_r10_black: assert property (@(posedge clk) disable iff (!rst_n)
        (!pattern_en || !disp_en) |=> (rgb_out == '0));

    // R2: delayed enable follows the input by one edge
    a_r2_de_high: assert property (@(posedge clk) disable iff (!rst_n)
        disp_en |=> de_out);
    a_r2_de_low: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> !de_out);

    // R4: red band leaves green and blue dark
    a_r4_red_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_region == ST_RED) |=> (rgb_out[2*CH_W-1:0] == '0));

    // R9: gray band drives equal channels
    a_r9_gray_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_region == ST_GRAY) |=>
        (rgb_out[3*CH_W-1:2*CH_W] == rgb_out[2*CH_W-1:CH_W])
        && (rgb_out[2*CH_W-1:CH_W] == rgb_out[CH_W-1:0]));

    // R7: zero red divisor keeps the red band black
    a_r7_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_region == ST_RED && ramp_den[CNT_W-1:0] == '0) |=> (rgb_out == '0));
endmodule

// File: tb/tb_grad_pattern_gen.sv
`timescale 1ns/1ps
module tb_grad_pattern_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pattern_en = 1'b0;
    logic        disp_en = 1'b0;
    logic [11:0] col = '0;
    logic [11:0] active_width = 12'd48;
    logic [2:0]  region_count = 3'd3;
    logic [31:0] ramp_num = 32'h0F0F0F0F;
    logic [31:0] ramp_den = 32'h0F0F0F0F;
    logic [11:0] rgb_out;
    logic        de_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [11:0] got;

    always #10 clk = ~clk;

    grad_pattern_gen dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pattern_en  (pattern_en),
        .disp_en     (disp_en),
        .col         (col),
        .active_width(active_width),
        .region_count(region_count),
        .ramp_num    (ramp_num),
        .ramp_den    (ramp_den),
        .rgb_out     (rgb_out),
        .de_out      (de_out)
    );

    typedef struct packed {
        logic [11:0] aw;
        logic [2:0]  rc;
        logic [31:0] num;
        logic [31:0] den;
        logic [11:0] probe;
        logic [11:0] exp_rgb;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{12'd48,   3'd3, 32'h0F0F0F0F, 32'h0F0F0F0F, 12'd5,   12'h500},
        '{12'd48,   3'd3, 32'h0F0F0F0F, 32'h0F0F0F0F, 12'd20,  12'h040},
        '{12'd48,   3'd3, 32'h0F0F0F0F, 32'h0F0F0F0F, 12'd47,  12'h00F},
        '{12'd48,   3'd4, 32'h0F0F0F0F, 32'h0F0F0F0F, 12'd40,  12'h444},
        '{12'd48,   3'd4, 32'h0F0F0F0F, 32'h0F0F0F0F, 12'd35,  12'h00B},
        '{12'd50,   3'd3, 32'h0F0F0F0F, 32'h0F0F0F0F, 12'd49,  12'h001},
        '{12'd480,  3'd3, 32'h0F0F0F0F, 32'h9F9F9F9F, 12'd100, 12'h900},
        '{12'd1200, 3'd3, 32'h01010101, 32'h10101010, 12'd300, 12'h200},
        '{12'd48,   3'd3, 32'h0F0F0F0F, 32'h00000000, 12'd20,  12'h000},
        '{12'd48,   3'd5, 32'h0F0F0F0F, 32'h0F0F0F0F, 12'd40,  12'h008},
        '{12'd48,   3'd4, 32'h02010301, 32'h01010101, 12'd14,  12'h060},
        '{12'd48,   3'd4, 32'h02010301, 32'h01010101, 12'd45,  12'h222}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1, 2: return "R4 band order";
            3, 4:    return "R3 four bands";
            5:       return "R8 remainder in last band";
            6:       return "R6 fractional scale";
            7:       return "R5 counter wrap";
            8:       return "R7 zero divisor";
            9:       return "R3 other count gives three";
            10:      return "R6 per-band bytes";
            default: return "R9 gray equal channels";
        endcase
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one active line; capture the colour for column 'probe'
    task automatic scan_line(input int aw, input int probe, output logic [11:0] cap);
        cap = 'x;
        for (int c = 0; c < aw; c++) begin
            @(negedge clk);
            disp_en = 1'b1;
            col     = 12'(c);
            @(posedge clk);
            #2;
            if (c == probe) cap = rgb_out;
        end
        @(negedge clk);
        disp_en = 1'b0;
        col     = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, with enables high to show they are held off
        disp_en    = 1'b1;
        pattern_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset rgb", rgb_out, 12'h000);
        check("R1 reset de", {11'd0, de_out}, 12'h000);
        @(negedge clk);
        disp_en = 1'b0;
        rst_n   = 1'b1;
        repeat (2) @(negedge clk);

        // R2: enable latency
        disp_en = 1'b1;
        col     = '0;
        #1;
        check("R2 de before edge", {11'd0, de_out}, 12'h000);
        @(posedge clk);
        #2;
        check("R2 de after edge", {11'd0, de_out}, 12'h001);
        check("R2 colour col0", rgb_out, 12'h000);
        @(negedge clk);
        disp_en = 1'b0;
        @(posedge clk);
        #2;
        check("R2 de falls", {11'd0, de_out}, 12'h000);
        check("R10 blanking black", rgb_out, 12'h000);
        repeat (2) @(negedge clk);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            active_width = VECS[i].aw;
            region_count = VECS[i].rc;
            ramp_num     = VECS[i].num;
            ramp_den     = VECS[i].den;
            scan_line(int'(VECS[i].aw), int'(VECS[i].probe), got);
            check(vec_tag(i), got, VECS[i].exp_rgb);
        end

        // R10: pattern disabled gives black in an active red pixel
        @(negedge clk);
        pattern_en   = 1'b0;
        active_width = 12'd48;
        region_count = 3'd3;
        ramp_num     = 32'h0F0F0F0F;
        ramp_den     = 32'h0F0F0F0F;
        scan_line(48, 5, got);
        check("R10 pattern off", got, 12'h000);

        // R10: re-enabled gives the ramp back
        @(negedge clk);
        pattern_en = 1'b1;
        scan_line(48, 5, got);
        check("R10 pattern on again", got, 12'h500);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule